// File: doc/BRIEF.md
# SDRAM Command-Mode Sequencer

This block turns one write to a command register into the one-shot SDRAM commands used to set up external memory and to control its low-power states. Each write carries a 3-bit mode code, one target-select bit per device, a repeat count for auto-refresh and a 13-bit mode-register value. A write starts its command as soon as it is accepted. No separate start bit is needed. Each target bit drives its own chip select, so one write can reach one device or both devices in the same cycle.

The block holds a busy flag while the delay after a command is still running. This covers the mode-load-to-activate wait, the precharge time and the spacing between refreshes in a run. When both devices are targeted, the mode-load delay is taken from device 0's setting. The precharge and row-cycle times exist only once and apply to both devices. A write that arrives while the block is busy is thrown away and sets a sticky error flag. When nothing is being issued, the bus carries NOP.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After a synchronous reset the block drives the following: `sd_cs_n`=2'b11, RAS/CAS/WE all 1, `sd_addr`=0, `sd_cke`=0, `busy`=0 and `cmd_err`=0.
- R2: A write is accepted at a rising edge where `wr_en`=1 and `busy`=0. A command that uses the bus appears for exactly one cycle, after that edge. `sd_cs_n[d]` is low exactly when `wr_tgt[d]`=1, so both devices can be selected in the same cycle.
- R3: Mode codes are 3'b001 clock enable, 3'b010 precharge all, 3'b011 auto-refresh, 3'b100 load mode register, 3'b101 self-refresh entry and 3'b110 power-down entry. The strobes {RAS,CAS,WE} are 010 for precharge all, 001 for auto-refresh and self-refresh, and 000 for load mode register.
- R4: Load mode register drives `wr_mrv` on `sd_addr` and keeps `busy` high for tmrd+1 cycles. tmrd comes from `tmrd_dev1` only when `wr_tgt`=2'b10; otherwise it comes from `tmrd_dev0`.
- R5: Auto-refresh issues `wr_nref`+1 refresh commands, spaced `t_rc`+1 cycles apart, starting in the first cycle. `busy` stays high for (`wr_nref`+1)*(`t_rc`+1) cycles.
- R6: An auto-refresh write with `wr_nref`=4'b1111 produces no command, and `busy` stays low.
- R7: Mode codes 3'b000 and 3'b111, and any write with `wr_tgt`=2'b00, produce no command. They leave `busy` low and do not set `cmd_err`.
- R8: Clock enable sets `sd_cke` of each targeted device. Self-refresh and power-down clear it. Non-targeted devices keep their value. Clock enable and power-down leave the bus at NOP. These three commands hold `busy` for one cycle.
- R9: Precharge all drives `sd_addr` bit 10 high with all other address bits low, and holds `busy` for `t_rp`+1 cycles.
- R10: A write with `busy`=1 is dropped: the bus is unaffected. `cmd_err` goes to 1 in the next cycle and stays there until reset.
- R11: Whenever no command is being issued, including every cycle with `busy`=0, the bus carries NOP: `sd_cs_n`=2'b11, strobes 111 and `sd_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command register write strobe |
| wr_mode | input | 3 | Mode code |
| wr_tgt | input | 2 | Per-device target selects |
| wr_nref | input | 4 | Auto-refresh count minus one |
| wr_mrv | input | 13 | Mode-register value |
| tmrd_dev0 | input | 4 | Device 0 mode-load delay minus one |
| tmrd_dev1 | input | 4 | Device 1 mode-load delay minus one |
| t_rc | input | 4 | Shared row-cycle time minus one |
| t_rp | input | 4 | Shared precharge time minus one |
| sd_cs_n | output | 2 | Chip selects, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | Address lines |
| sd_cke | output | 2 | Per-device clock enable |
| busy | output | 1 | Command or its delay in progress |
| cmd_err | output | 1 | Sticky dropped-write flag |

## Verification
The hardest case to reach is a write that lands while a long refresh run is still busy. It must be dropped without disturbing the later refresh commands in the run. The stimulus creates this by holding the write strobe for one extra cycle right after an accepted command, with the fields changed to a load-mode write to both devices that would show up on the bus if it got through. It then checks every remaining cycle of the run. A further directed case selects only device 1 with two different mode-load delays, to show which delay is used.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [2:0] {
    MD_NORMAL = 3'b000,
    MD_CKE_ON = 3'b001,
    MD_PALL   = 3'b010,
    MD_AREF   = 3'b011,
    MD_LMR    = 3'b100,
    MD_SELF   = 3'b101,
    MD_PDOWN  = 3'b110,
    MD_RSVD   = 3'b111
  } sdcmd_mode_e;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] STRB_NOP  = 3'b111;
  localparam logic [2:0] STRB_PALL = 3'b010;
  localparam logic [2:0] STRB_AREF = 3'b001;
  localparam logic [2:0] STRB_LMR  = 3'b000;
  localparam int         PALL_ABIT = 10;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int NDEV = 2,
  parameter int AW   = 13,
  parameter int TW   = 4,
  parameter int CW   = 4,
  localparam int LW  = TW + 1
) (
  input  logic [2:0]      mode,
  input  logic [NDEV-1:0] tgt,
  input  logic [CW-1:0]   nref,
  input  logic [AW-1:0]   mrv,
  input  logic [TW-1:0]   tmrd0,
  input  logic [TW-1:0]   tmrd1,
  input  logic [TW-1:0]   trc,
  input  logic [TW-1:0]   trp,
  output logic            valid,
  output logic            on_bus,
  output logic [2:0]      strb,
  output logic [AW-1:0]   addr,
  output logic [LW-1:0]   len,
  output logic [CW-1:0]   reps,
  output logic            cke_set,
  output logic            cke_clr
);
  sdcmd_mode_e m;
  logic [TW-1:0] tmrd_sel;

  assign m = sdcmd_mode_e'(mode);
  // device 0 timing governs unless device 1 alone is targeted
  assign tmrd_sel = (tgt == NDEV'(2)) ? tmrd1 : tmrd0;

  always_comb begin
    valid   = (tgt != '0);
    on_bus  = 1'b0;
    strb    = STRB_NOP;
    addr    = '0;
    len     = LW'(1);
    reps    = '0;
    cke_set = 1'b0;
    cke_clr = 1'b0;
    case (m)
      MD_CKE_ON: cke_set = 1'b1;
      MD_PALL: begin
        on_bus = 1'b1;
        strb   = STRB_PALL;
        addr[PALL_ABIT] = 1'b1;
        len    = LW'(trp) + LW'(1);
      end
      MD_AREF: begin
        on_bus = 1'b1;
        strb   = STRB_AREF;
        len    = LW'(trc) + LW'(1);
        reps   = nref;
        if (nref == '1) valid = 1'b0;
      end
      MD_LMR: begin
        on_bus = 1'b1;
        strb   = STRB_LMR;
        addr   = mrv;
        len    = LW'(tmrd_sel) + LW'(1);
      end
      MD_SELF: begin
        on_bus  = 1'b1;
        strb    = STRB_AREF;
        cke_clr = 1'b1;
      end
      MD_PDOWN: cke_clr = 1'b1;
      default: valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/sdcmd_timer.sv
module sdcmd_timer #(
  parameter int LW = 5,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic [CW-1:0] reps,
  output logic          busy,
  output logic          reissue
);
  logic [LW-1:0] cnt, len_q;
  logic [CW-1:0] rep;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      len_q <= '0;
      rep   <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= len - LW'(1);
      len_q <= len;
      rep   <= reps;
    end else if (busy) begin
      if (cnt == '0) begin
        if (rep == '0) begin
          busy <= 1'b0;
        end else begin
          rep <= rep - CW'(1);
          cnt <= len_q - LW'(1);
        end
      end else begin
        cnt <= cnt - LW'(1);
      end
    end
  end

  assign reissue = busy && (cnt == '0) && (rep != '0);

  AST_REP_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rep != '1)); // R6
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdcmd_pkg::*;
#(
  parameter int NDEV = 2,
  parameter int AW   = 13,
  parameter int TW   = 4,
  parameter int CW   = 4,
  localparam int LW  = TW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [2:0]      wr_mode,
  input  logic [NDEV-1:0] wr_tgt,
  input  logic [CW-1:0]   wr_nref,
  input  logic [AW-1:0]   wr_mrv,
  input  logic [TW-1:0]   tmrd_dev0,
  input  logic [TW-1:0]   tmrd_dev1,
  input  logic [TW-1:0]   t_rc,
  input  logic [TW-1:0]   t_rp,
  output logic [NDEV-1:0] sd_cs_n,
  output logic            sd_ras_n,
  output logic            sd_cas_n,
  output logic            sd_we_n,
  output logic [AW-1:0]   sd_addr,
  output logic [NDEV-1:0] sd_cke,
  output logic            busy,
  output logic            cmd_err
);
  logic            d_valid, d_bus, d_set, d_clr, go, reissue;
  logic [2:0]      d_strb;
  logic [AW-1:0]   d_addr;
  logic [LW-1:0]   d_len;
  logic [CW-1:0]   d_reps;
  logic [NDEV-1:0] held_cs_n;

  sdcmd_decode #(.NDEV(NDEV), .AW(AW), .TW(TW), .CW(CW)) u_dec (
    .mode(wr_mode), .tgt(wr_tgt), .nref(wr_nref), .mrv(wr_mrv),
    .tmrd0(tmrd_dev0), .tmrd1(tmrd_dev1), .trc(t_rc), .trp(t_rp),
    .valid(d_valid), .on_bus(d_bus), .strb(d_strb), .addr(d_addr),
    .len(d_len), .reps(d_reps), .cke_set(d_set), .cke_clr(d_clr)
  );

  assign go = wr_en && !busy && d_valid;

  sdcmd_timer #(.LW(LW), .CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .start(go), .len(d_len), .reps(d_reps),
    .busy(busy), .reissue(reissue)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_cs_n   <= '1;
      {sd_ras_n, sd_cas_n, sd_we_n} <= STRB_NOP;
      sd_addr   <= '0;
      held_cs_n <= '1;
      cmd_err   <= 1'b0;
    end else begin
      sd_cs_n <= '1;
      {sd_ras_n, sd_cas_n, sd_we_n} <= STRB_NOP;
      sd_addr <= '0;
      if (go) begin
        held_cs_n <= ~wr_tgt;
        if (d_bus) begin
          sd_cs_n <= ~wr_tgt;
          {sd_ras_n, sd_cas_n, sd_we_n} <= d_strb;
          sd_addr <= d_addr;
        end
      end else if (reissue) begin
        sd_cs_n <= held_cs_n;
        {sd_ras_n, sd_cas_n, sd_we_n} <= STRB_AREF;
      end
      if (wr_en && busy) cmd_err <= 1'b1;
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_cke
    always_ff @(posedge clk) begin
      if (rst) sd_cke[d] <= 1'b0;
      else if (go && wr_tgt[d]) begin
        if (d_set)      sd_cke[d] <= 1'b1;
        else if (d_clr) sd_cke[d] <= 1'b0;
      end
    end
  end

  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sd_cs_n == '1)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> cmd_err); // R10
  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> cmd_err); // R10
  AST_LMR_ADDR: assert property (@(posedge clk) disable iff (rst)
    ((sd_cs_n != '1) && {sd_ras_n, sd_cas_n, sd_we_n} == STRB_LMR)
      |-> (sd_addr == $past(wr_mrv))); // R4
endmodule

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_mode = '0;
  logic [1:0] wr_tgt = '0;
  logic [3:0] wr_nref = '0, tmrd_dev0 = '0, tmrd_dev1 = '0, t_rc = '0, t_rp = '0;
  logic [12:0] wr_mrv = '0;
  logic [1:0] sd_cs_n, sd_cke;
  logic sd_ras_n, sd_cas_n, sd_we_n, busy, cmd_err;
  logic [12:0] sd_addr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0] exp_cke = 2'b00;
  logic exp_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_seq u_sdram_cmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode), .wr_tgt(wr_tgt),
    .wr_nref(wr_nref), .wr_mrv(wr_mrv), .tmrd_dev0(tmrd_dev0),
    .tmrd_dev1(tmrd_dev1), .t_rc(t_rc), .t_rp(t_rp), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_cke(sd_cke), .busy(busy), .cmd_err(cmd_err)
  );

  // {busy, err, cke, cs_n, ras, cas, we, addr}
  function automatic logic [21:0] pack_exp(logic b, logic e, logic [1:0] k,
      logic [1:0] cs, logic [2:0] s, logic [12:0] a);
    return {b, e, k, cs, s, a};
  endfunction

  function automatic string tag_of(logic [2:0] m, logic [1:0] t, logic [3:0] n);
    if (t == 2'b00 || m == 3'b000 || m == 3'b111) return "R7";
    case (m)
      3'b010: return "R9";
      3'b011: return (n == 4'hF) ? "R6" : "R5";
      3'b100: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [21:0] exp);
    logic [21:0] act;
    act = {busy, cmd_err, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(logic [2:0] m, logic [1:0] t, logic [3:0] n,
                         logic [12:0] v, bit drop, string tag);
    bit ok, bus;
    int len, total;
    logic [2:0] s;
    logic [12:0] a;
    logic [1:0] kn;
    @(negedge clk);
    wr_en = 1; wr_mode = m; wr_tgt = t; wr_nref = n; wr_mrv = v;
    ok = (t != 0) && (m != 3'b000) && (m != 3'b111) && !(m == 3'b011 && n == 4'hF);
    bus = 0; s = 3'b111; a = '0; len = 1; kn = exp_cke; total = 0;
    case (m)
      3'b001: kn = exp_cke | t;
      3'b010: begin bus = 1; s = 3'b010; a = 13'h400; len = t_rp + 1; end
      3'b011: begin bus = 1; s = 3'b001; len = t_rc + 1; end
      3'b100: begin bus = 1; s = 3'b000; a = v;
                    len = (t == 2'b10) ? tmrd_dev1 + 1 : tmrd_dev0 + 1; end
      3'b101: begin bus = 1; s = 3'b001; kn = exp_cke & ~t; end
      3'b110: kn = exp_cke & ~t;
      default: ;
    endcase
    if (ok) begin
      total = (m == 3'b011) ? (n + 1) * len : len;
      exp_cke = kn;
    end
    if (tag == "") tag = tag_of(m, t, n);
    drop = drop && ok;
    @(negedge clk);
    if (drop) begin wr_mode = 3'b100; wr_tgt = 2'b11; wr_mrv = ~v; end
    else wr_en = 0;
    for (int i = 0; i <= total; i++) begin
      bit iss;
      if (i > 0) @(negedge clk);
      if (i == 1 && drop) begin wr_en = 0; exp_err = 1; end
      iss = bus && (i < total) && (i % len == 0);
      check((i >= total) ? "R11" : (drop && i > 0) ? "R10" : tag,
            pack_exp(i < total, exp_err, exp_cke, iss ? ~t : 2'b11,
                     iss ? s : 3'b111, iss ? a : 13'h0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1", pack_exp(0, 0, 2'b00, 2'b11, 3'b111, 13'h0));
    // directed corner cases
    tmrd_dev0 = 4'd2; tmrd_dev1 = 4'd6; t_rc = 4'd1; t_rp = 4'd3;
    run_cmd(3'b001, 2'b11, 0, 0, 0, "R8");
    run_cmd(3'b100, 2'b01, 0, 13'h1A5, 0, "R2");
    run_cmd(3'b100, 2'b10, 0, 13'h0F3, 0, "R4");
    run_cmd(3'b100, 2'b11, 0, 13'h1234, 0, "R4");
    run_cmd(3'b010, 2'b11, 0, 0, 0, "R3");
    run_cmd(3'b011, 2'b11, 4'hF, 0, 0, "R6");
    run_cmd(3'b011, 2'b10, 4'd14, 0, 0, "R5");
    t_rc = 4'd0;
    run_cmd(3'b011, 2'b01, 4'd3, 0, 0, "R5");
    run_cmd(3'b000, 2'b11, 0, 0, 0, "R7");
    run_cmd(3'b111, 2'b11, 0, 0, 0, "R7");
    run_cmd(3'b100, 2'b00, 0, 13'h1FFF, 0, "R7");
    run_cmd(3'b110, 2'b01, 0, 0, 0, "R8");
    run_cmd(3'b101, 2'b10, 0, 0, 0, "R3");
    t_rc = 4'd5;
    run_cmd(3'b011, 2'b11, 4'd4, 0, 1, "R10");
    // random commands
    for (int k = 0; k < 80; k++) begin
      tmrd_dev0 = 4'($urandom); tmrd_dev1 = 4'($urandom);
      t_rc = 4'($urandom); t_rp = 4'($urandom);
      run_cmd(3'($urandom), 2'($urandom), 4'($urandom), 13'($urandom),
              ($urandom % 8) == 0, "");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule